// File: doc/BRIEF.md
# Modem Line Watcher

This block watches the four inbound modem lines of a serial port: ring indicator, clear-to-send, carrier detect and data-set-ready. Each line is brought into the port clock domain through a flop chain, and the settled level of every line can be read back. Two of the lines, clear-to-send and carrier detect, also feed edge catchers. Each catcher holds a pending bit until software reads the status word. One summary request is raised for the port's main interrupt logic when a pending bit is enabled.

Software writes one configuration word. It holds a per-line enable for the summary request, a per-line choice between rising-edge-only and both-edge reporting, a global summary enable, and the two outbound control bits for terminal-ready and request-to-send. The outbound pins carry the inverse of what was written.

Top module: `modem_line_watch`

## Requirements
- R1: `stat_rdata[3:0]` show the synchronized levels of ring (bit 0), clear-to-send (bit 1), carrier detect (bit 2) and data-set-ready (bit 3). A change on an input pin is visible there after the second rising clock edge that samples it.
- R2: With the both-edge bit of a line clear, a rising level change sets that line's pending bit (`stat_rdata[4]` clear-to-send, `stat_rdata[5]` carrier detect) one edge after the level appears in bits 1 or 2. A falling change sets nothing.
- R3: With the both-edge bit of a line set (`cfg_wdata[2]` clear-to-send, `cfg_wdata[3]` carrier detect), a falling level change also sets the pending bit.
- R4: A cycle with `stat_rd` high returns the pending bits as they stand, and clears them at the closing edge.
- R5: An edge caught at the same clock edge that ends a read is kept pending and is not lost.
- R6: `modem_irq` is high exactly when the summary enable (`cfg_wdata[4]`) is set and some pending bit has its enable set (`cfg_wdata[0]` clear-to-send, `cfg_wdata[1]` carrier detect). Pending bits latch whatever their enable is.
- R7: `dtr_n` equals the inverse of the written bit `cfg_wdata[5]`, and `rts_n` equals the inverse of `cfg_wdata[6]`.
- R8: After reset, all configuration and pending bits are zero, `modem_irq` is low, and `dtr_n` and `rts_n` are high.
- R9: A cycle with `cfg_wr` high loads `cfg_wdata` at the clock edge. The word reads back in `stat_rdata[12:6]` with the same bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ring_i | input | 1 | Ring indicator line, asynchronous |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dcd_i | input | 1 | Carrier detect line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| cfg_wr | input | 1 | Load the configuration word |
| cfg_wdata | input | 7 | Configuration: [1:0] enables, [3:2] both-edge, [4] summary enable, [5] terminal-ready, [6] request-to-send |
| stat_rd | input | 1 | Status read strobe; clears pending bits |
| stat_rdata | output | 13 | [3:0] levels, [5:4] pending, [12:6] configuration |
| modem_irq | output | 1 | Summary request to the main interrupt logic |
| dtr_n | output | 1 | Terminal-ready pin, inverted |
| rts_n | output | 1 | Request-to-send pin, inverted |

## Verification
The hazardous overlap is a clearing read landing in the same cycle as a newly caught edge. A pending bit must then survive the clear rather than vanish with it. A directed sequence places the read strobe exactly on the edge that catches a rising clear-to-send transition and expects the bit still set afterwards. Random runs with frequent reads and line toggles then hit the same overlap many times, and a cycle-accurate model built from the requirements judges every cycle.

// File: rtl/mlw_pkg.sv
`timescale 1ns/1ps
// Package: shared layout of the modem line watcher.
// Assumes line index order ring, clear-to-send, carrier detect, data-set-ready.
package mlw_pkg;
    localparam int NUM_LINES    = 4;
    localparam int NUM_WATCHED  = 2;
    localparam int IDX_RING     = 0;
    localparam int IDX_CTS      = 1;
    localparam int IDX_DCD      = 2;
    localparam int IDX_DSR      = 3;
    localparam int FIRST_WATCHED = IDX_CTS;

    // Configuration word, most significant field first.
    typedef struct packed {
        logic                   rts_ctl;
        logic                   dtr_ctl;
        logic                   sum_en;
        logic [NUM_WATCHED-1:0] both_edge;
        logic [NUM_WATCHED-1:0] line_en;
    } cfg_t;

    localparam int CFG_W  = $bits(cfg_t);
    localparam int STAT_W = CFG_W + NUM_WATCHED + NUM_LINES;
endpackage

// File: rtl/mlw_sync_chain.sv
`timescale 1ns/1ps
// Module: multi-bit flop chain that moves asynchronous levels into clk.
// Assumes each bit is independent; no bus coherence is promised.
module mlw_sync_chain #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First capture flop of the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= async_in;
                end
            end else begin : g_next
                // Further settling flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/mlw_edge_latch.sv
`timescale 1ns/1ps
// Module: catches edges on one synchronized line and holds a pending bit.
// Assumes level_in is already in the clk domain. A clear and a new edge in
// the same cycle leave the bit set.
module mlw_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic both_edge,
    input  logic clear,
    output logic pending
);
    logic level_prev_q;
    logic hit;

    // Remember last cycle's level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_prev_q <= 1'b0;
        else        level_prev_q <= level_in;
    end

    // Rising edge always counts; falling edge only in both-edge mode.
    always_comb begin
        hit = level_in & ~level_prev_q;
        if (both_edge) hit = level_in ^ level_prev_q;
    end

    // Pending bit: a new hit wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending & ~clear) | hit;
    end
endmodule

// File: rtl/modem_line_watch.sv
`timescale 1ns/1ps
// Module: modem line watcher top. Synchronizes four inbound lines, catches
// edges on clear-to-send and carrier detect, raises one summary request and
// drives the two outbound control pins inverted.
// Assumes stat_rd is a single-cycle strobe per software read.
module modem_line_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ring_i,
    input  logic                      cts_i,
    input  logic                      dcd_i,
    input  logic                      dsr_i,
    input  logic                      cfg_wr,
    input  logic [mlw_pkg::CFG_W-1:0] cfg_wdata,
    input  logic                      stat_rd,
    output logic [mlw_pkg::STAT_W-1:0] stat_rdata,
    output logic                      modem_irq,
    output logic                      dtr_n,
    output logic                      rts_n
);
    import mlw_pkg::*;

    logic [NUM_LINES-1:0]   raw_lines;
    logic [NUM_LINES-1:0]   sync_lines;
    logic [NUM_WATCHED-1:0] pend;
    cfg_t                   cfg_q;

    assign raw_lines[IDX_RING] = ring_i;
    assign raw_lines[IDX_CTS]  = cts_i;
    assign raw_lines[IDX_DCD]  = dcd_i;
    assign raw_lines[IDX_DSR]  = dsr_i;

    mlw_sync_chain #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lines),
        .sync_out (sync_lines)
    );

    // Configuration word, loaded whole on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_t'(cfg_wdata);
    end

    genvar w;
    generate
        for (w = 0; w < NUM_WATCHED; w++) begin : g_watch
            mlw_edge_latch u_edge (
                .clk       (clk),
                .rst_n     (rst_n),
                .level_in  (sync_lines[FIRST_WATCHED + w]),
                .both_edge (cfg_q.both_edge[w]),
                .clear     (stat_rd),
                .pending   (pend[w])
            );
        end
    endgenerate

    // Status word and outbound signals.
    assign stat_rdata = {cfg_q, pend, sync_lines};
    assign modem_irq  = cfg_q.sum_en & (|(pend & cfg_q.line_en));
    assign dtr_n      = ~cfg_q.dtr_ctl;
    assign rts_n      = ~cfg_q.rts_ctl;
endmodule

// File: rtl/mlw_checker.sv
`timescale 1ns/1ps
// Module: property checker for modem_line_watch, attached by bind.
// Assumes the default status layout from mlw_pkg.
module mlw_checker #(
    parameter int SYNC_STAGES = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ring_i,
    input logic        cts_i,
    input logic        dcd_i,
    input logic        dsr_i,
    input logic        cfg_wr,
    input logic [6:0]  cfg_wdata,
    input logic        stat_rd,
    input logic [12:0] stat_rdata,
    input logic        modem_irq,
    input logic        dtr_n,
    input logic        rts_n
);
    logic [1:0] age_q;
    logic       armed;
    logic       settled;

    // Cycles since reset, saturating, to keep history checks honest.
    always_ff @(posedge clk) begin
        if (!rst_n)          age_q <= '0;
        else if (age_q != 3) age_q <= age_q + 2'd1;
    end
    assign armed   = (age_q != 0);
    assign settled = (age_q >= 2);

    generate
        if (SYNC_STAGES == 2) begin : g_lvl
            AST_LEVEL_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
                settled |-> stat_rdata[3:0] == $past({dsr_i, dcd_i, cts_i, ring_i}, 2)); // R1
        end
    endgenerate

    AST_RISE_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(stat_rdata[1])) |=> stat_rdata[4]); // R2

    AST_FALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !stat_rdata[8] && $fell(stat_rdata[1]) && !stat_rdata[4]) |=> !stat_rdata[4]); // R2

    AST_BOTH_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && stat_rdata[9] && $fell(stat_rdata[2])) |=> stat_rdata[5]); // R3

    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && stat_rd && $stable(stat_rdata[2:1])) |=> stat_rdata[5:4] == 2'b00); // R4

    AST_CLASH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && stat_rd && $rose(stat_rdata[1])) |=> stat_rdata[4]); // R5

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[7:6] == 2'b00 || !stat_rdata[10]) |-> !modem_irq); // R6

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(modem_irq)) |-> (stat_rdata[5:4] != 2'b00)); // R6

    AST_PIN_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (dtr_n == !$past(cfg_wdata[5])) && (rts_n == !$past(cfg_wdata[6]))); // R7
endmodule

bind modem_line_watch mlw_checker #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_i     (ring_i),
    .cts_i      (cts_i),
    .dcd_i      (dcd_i),
    .dsr_i      (dsr_i),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .stat_rd    (stat_rd),
    .stat_rdata (stat_rdata),
    .modem_irq  (modem_irq),
    .dtr_n      (dtr_n),
    .rts_n      (rts_n)
);

// File: tb/sim_modem_line_watch.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic, every cycle
// compared against a model written from the requirements.
module sim_modem_line_watch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pins = '0;
    logic        cfg_wr = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic        stat_rd = 1'b0;
    logic [12:0] stat_rdata;
    logic        modem_irq, dtr_n, rts_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    modem_line_watch u0 (
        .clk(clk), .rst_n(rst_n),
        .ring_i(pins[0]), .cts_i(pins[1]), .dcd_i(pins[2]), .dsr_i(pins[3]),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .stat_rd(stat_rd),
        .stat_rdata(stat_rdata), .modem_irq(modem_irq), .dtr_n(dtr_n), .rts_n(rts_n)
    );

    // Reference model state.
    logic [3:0] m_s1, m_s2;
    logic [1:0] m_prev, m_pend;
    logic [6:0] m_cfg;

    always @(posedge clk) begin
        logic [1:0] h;
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0; m_cfg <= '0;
        end else begin
            for (int k = 0; k < 2; k++)
                h[k] = m_cfg[2+k] ? (m_s2[1+k] ^ m_prev[k]) : (m_s2[1+k] & ~m_prev[k]);
            m_s1 <= pins;
            m_s2 <= m_s1;
            m_prev <= m_s2[2:1];
            m_pend <= (m_pend & ~{2{stat_rd}}) | h;
            if (cfg_wr) m_cfg <= cfg_wdata;
        end
    end

    function automatic logic exp_irq(input logic [6:0] c, input logic [1:0] p);
        return c[4] & (|(p & c[1:0]));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 levels", stat_rdata[3:0], m_s2);
        chk("R2 pending", stat_rdata[5:4], m_pend);
        chk("R9 config", stat_rdata[12:6], m_cfg);
        chk("R6 irq", modem_irq, exp_irq(m_cfg, m_pend));
        chk("R7 pins", {rts_n, dtr_n}, {~m_cfg[6], ~m_cfg[5]});
    endtask

    // One cycle: compare after the last edge, then drive the next inputs.
    task automatic cyc(input logic [3:0] p, input logic rd, input logic wr, input logic [6:0] wd);
        @(negedge clk);
        if (rst_n) compare_all();
        pins = p; stat_rd = rd; cfg_wr = wr; cfg_wdata = wd;
    endtask

    task automatic idle(input int n, input logic [3:0] p);
        for (int i = 0; i < n; i++) cyc(p, 1'b0, 1'b0, '0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset status", stat_rdata, 0);
        chk("R8 reset irq", modem_irq, 0);
        chk("R8 reset dtr_n", dtr_n, 1);
        chk("R8 reset rts_n", rts_n, 1);

        // Rising clear-to-send, rising-only mode.
        cyc(4'b0010, 0, 0, '0);
        idle(2, 4'b0010);
        chk("R1 cts level", stat_rdata[1], 1);
        idle(1, 4'b0010);
        chk("R2 rise sets pending", stat_rdata[4], 1);
        cyc(4'b0010, 1, 0, '0);
        idle(1, 4'b0010);
        chk("R4 read clears", stat_rdata[4], 0);
        // Falling edge must not set anything.
        idle(5, 4'b0000);
        chk("R2 fall ignored", stat_rdata[4], 0);

        // Both-edge mode on carrier detect.
        cyc(4'b0100, 0, 1, 7'b0001000);
        idle(4, 4'b0100);
        cyc(4'b0100, 1, 0, '0);
        idle(1, 4'b0000);
        chk("R4 cleared before fall", stat_rdata[5], 0);
        idle(4, 4'b0000);
        chk("R3 fall sets pending", stat_rdata[5], 1);
        cyc(4'b0000, 1, 0, '0);

        // Read on the very edge that catches a new rise.
        cyc(4'b0010, 0, 0, '0);
        cyc(4'b0010, 0, 0, '0);
        cyc(4'b0010, 1, 0, '0);
        idle(1, 4'b0010);
        chk("R5 clash keeps edge", stat_rdata[4], 1);

        // Summary request gating.
        cyc(4'b0010, 0, 1, 7'b0010000);
        idle(1, 4'b0010);
        chk("R6 disabled line no irq", modem_irq, 0);
        chk("R6 pending held when disabled", stat_rdata[4], 1);
        cyc(4'b0010, 0, 1, 7'b0010001);
        idle(1, 4'b0010);
        chk("R6 enabled irq", modem_irq, 1);

        // Outbound pin inversion.
        cyc(4'b0010, 0, 1, 7'b0100000);
        idle(1, 4'b0010);
        chk("R7 dtr_n", dtr_n, 0);
        chk("R7 rts_n", rts_n, 1);

        // Seeded random traffic.
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] p;
            p = pins;
            if ($urandom_range(0, 3) == 0) p = p ^ 4'($urandom_range(0, 15));
            cyc(p, ($urandom_range(0, 5) == 0), ($urandom_range(0, 24) == 0),
                7'($urandom_range(0, 127)));
        end
        idle(3, pins);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule